// File: doc/BRIEF.md
# AES Key-Expansion Assist Unit

This unit performs the word-level step that an AES key schedule needs in each round. It takes a 128-bit block and an 8-bit round constant. Two of the four 32-bit words in the block go through the forward AES S-box, one byte at a time. The unit then forms a rotated copy of each substituted word and XORs the round constant into that rotated copy. The four resulting words are packed into one registered 128-bit result.

The caller owns the key-schedule sequencing. It presents the previous round key together with the round constant for the next round. It then takes the top output word (the rotated, substituted and constant-mixed copy of the highest input word) and folds it into the previous key with the usual XOR chain. Words 0 and 2 of the input are discarded. A new result is captured whenever `in_valid` is high, and `out_valid` marks it one clock later.

Top module: `aes_keygen_assist`

## Requirements
- R1: Result bits 31:0 equal SubWord(W1), where W1 = blk_in[63:32] and SubWord applies the forward AES S-box to each byte on its own (for example S(00)=63, S(01)=7C, S(53)=ED, S(FF)=16).
- R2: Result bits 63:32 equal RotWord(SubWord(W1)) XOR RCON. RotWord maps bytes {b3,b2,b1,b0} to {b0,b3,b2,b1}, with b0 in bits 7:0.
- R3: Result bits 95:64 equal SubWord(W3), where W3 = blk_in[127:96].
- R4: Result bits 127:96 equal RotWord(SubWord(W3)) XOR RCON. Fed the previous round key, this word yields the standard AES-128 key expansion.
- R5: Input words W0 (bits 31:0) and W2 (bits 95:64) have no effect on the result.
- R6: RCON is rc_in zero-extended to 32 bits. Only bits 7:0 of result words 1 and 3 depend on rc_in.
- R7: out_valid is high exactly in the cycle after a clock edge that sampled in_valid high, and that edge loads the new result.
- R8: Asserting rst_n low clears out_valid at once, without waiting for a clock edge.
- R9: While in_valid is low, blk_out holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Load enable for a new operation |
| blk_in | input | 128 | Input block (previous round key) |
| rc_in | input | 8 | Round constant immediate |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| blk_out | output | 128 | Registered four-word result |

## Verification
Every result is due exactly one rising edge after the edge that samples in_valid. The bench drives inputs on a falling edge, lets one rising edge pass, and reads blk_out and out_valid at the next falling edge. It then drops in_valid and checks that the result stays put for the following cycle. The reset check looks at out_valid a moment after rst_n falls, before any clock edge, so it confirms that the clear does not wait for the clock.

// File: rtl/aes_ka_pkg.sv
package aes_ka_pkg;

  localparam int BYTE_W  = 8;
  localparam int WORD_B  = 4;
  localparam int WORD_W  = BYTE_W * WORD_B;
  localparam int BLK_W   = 128;
  localparam int NWORDS  = BLK_W / WORD_W;
  localparam logic [BYTE_W-1:0] AFF_C = 8'h63;
  localparam logic [BYTE_W-1:0] GF_POLY = 8'h1B;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;

  // multiply in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic byte_t gf_mul(input byte_t x, input byte_t y);
    byte_t acc;
    byte_t p;
    acc = '0;
    p   = x;
    for (int i = 0; i < BYTE_W; i++) begin
      if (y[i]) acc = acc ^ p;
      p = p[BYTE_W-1] ? ((p << 1) ^ GF_POLY) : (p << 1);
    end
    return acc;
  endfunction

  // multiplicative inverse as x^254 (0 maps to 0)
  function automatic byte_t gf_inv(input byte_t x);
    byte_t r;
    byte_t p;
    logic [7:0] e;
    r = 8'h01;
    p = x;
    e = 8'd254;
    for (int i = 0; i < 8; i++) begin
      if (e[i]) r = gf_mul(r, p);
      p = gf_mul(p, p);
    end
    return r;
  endfunction

  function automatic byte_t rotl8(input byte_t v, input int n);
    return byte_t'((v << n) | (v >> (BYTE_W - n)));
  endfunction

  function automatic byte_t sbox_fwd(input byte_t x);
    byte_t q;
    q = gf_inv(x);
    return q ^ rotl8(q, 1) ^ rotl8(q, 2) ^ rotl8(q, 3) ^ rotl8(q, 4) ^ AFF_C;
  endfunction

endpackage

// File: rtl/aes_ka_sbox.sv
module aes_ka_sbox
  import aes_ka_pkg::*;
(
  input  logic [BYTE_W-1:0] d_i,
  output logic [BYTE_W-1:0] s_o
);
  always_comb begin
    s_o = sbox_fwd(d_i);
  end
endmodule

// File: rtl/aes_ka_subword.sv
module aes_ka_subword
  import aes_ka_pkg::*;
#(
  parameter int NB = WORD_B
) (
  input  logic [NB*BYTE_W-1:0] w_i,
  output logic [NB*BYTE_W-1:0] w_o
);
  for (genvar g = 0; g < NB; g++) begin : g_lane
    aes_ka_sbox u_sb (
      .d_i (w_i[g*BYTE_W +: BYTE_W]),
      .s_o (w_o[g*BYTE_W +: BYTE_W])
    );
  end
endmodule

// File: rtl/aes_ka_pack.sv
module aes_ka_pack
  import aes_ka_pkg::*;
(
  input  logic [WORD_W-1:0] sub_lo_i,
  input  logic [WORD_W-1:0] sub_hi_i,
  input  logic [BYTE_W-1:0] rc_i,
  output logic [BLK_W-1:0]  blk_o
);
  localparam int NSRC = 2;

  logic [WORD_W-1:0] src  [NSRC];
  logic [WORD_W-1:0] rcon;

  assign src[0] = sub_lo_i;
  assign src[1] = sub_hi_i;
  assign rcon   = {{(WORD_W-BYTE_W){1'b0}}, rc_i};

  for (genvar k = 0; k < NSRC; k++) begin : g_pair
    // plain copy in the even word, rotated copy with constant in the odd word
    assign blk_o[(2*k)*WORD_W +: WORD_W]   = src[k];
    assign blk_o[(2*k+1)*WORD_W +: WORD_W] =
      {src[k][BYTE_W-1:0], src[k][WORD_W-1:BYTE_W]} ^ rcon;
  end
endmodule

// File: rtl/aes_keygen_assist.sv
module aes_keygen_assist
  import aes_ka_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BLK_W-1:0]  blk_in,
  input  logic [BYTE_W-1:0] rc_in,
  output logic              out_valid,
  output logic [BLK_W-1:0]  blk_out
);
  localparam int SEL_LO = 1;
  localparam int SEL_HI = 3;

  logic [WORD_W-1:0] sub_lo;
  logic [WORD_W-1:0] sub_hi;
  logic [BLK_W-1:0]  res_nxt;
  logic [BLK_W-1:0]  res_q;
  logic [BLK_W-1:0]  res_d;
  logic              vld_q;
  logic              vld_d;

  aes_ka_subword u_sub_lo (
    .w_i (blk_in[SEL_LO*WORD_W +: WORD_W]),
    .w_o (sub_lo)
  );

  aes_ka_subword u_sub_hi (
    .w_i (blk_in[SEL_HI*WORD_W +: WORD_W]),
    .w_o (sub_hi)
  );

  aes_ka_pack u_pack (
    .sub_lo_i (sub_lo),
    .sub_hi_i (sub_hi),
    .rc_i     (rc_in),
    .blk_o    (res_nxt)
  );

  always_comb begin
    vld_d = in_valid;
    res_d = res_q;
    if (in_valid) res_d = res_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  // datapath register: no reset, load under enable
  always_ff @(posedge clk) begin
    if (in_valid) res_q <= res_d;
  end

  assign out_valid = vld_q;
  assign blk_out   = res_q;
endmodule

// File: rtl/aes_keygen_assist_chk.sv
module aes_keygen_assist_chk
  import aes_ka_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [BYTE_W-1:0] rc_in,
  input logic              out_valid,
  input logic [BLK_W-1:0]  blk_out
);
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R7
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R7
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !in_valid) |=> $stable(blk_out)); // R9
  AST_ROT_LO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (blk_out[63:40] == {blk_out[7:0], blk_out[31:16]})); // R2
  AST_ROT_HI: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (blk_out[127:104] == {blk_out[71:64], blk_out[95:80]})); // R4
  AST_RCON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((blk_out[39:32] ^ blk_out[15:8]) == $past(rc_in))); // R6

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLR: assert (!out_valid); // R8
    end
  end
endmodule

bind aes_keygen_assist aes_keygen_assist_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .rc_in     (rc_in),
  .out_valid (out_valid),
  .blk_out   (blk_out)
);

// File: tb/aes_keygen_assist_test.sv
module aes_keygen_assist_test;
  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] blk_in;
  logic [7:0]   rc_in;
  logic         out_valid;
  logic [127:0] blk_out;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  aes_keygen_assist uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .blk_in    (blk_in),
    .rc_in     (rc_in),
    .out_valid (out_valid),
    .blk_out   (blk_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // AES-128 round keys 0..10 for the standard example key, byte 0 first
  localparam logic [127:0] KEY_BE [0:10] = '{
    128'h2b7e151628aed2a6abf7158809cf4f3c,
    128'ha0fafe1788542cb123a339392a6c7605,
    128'hf2c295f27a96b9435935807a7359f67f,
    128'h3d80477d4716fe3e1e237e446d7a883b,
    128'hef44a541a8525b7fb671253bdb0bad00,
    128'hd4d1c6f87c839d87caf2b8bc11f915bc,
    128'h6d88a37a110b3efddbf98641ca0093fd,
    128'h4e54f70e5f5fc9f384a64fb24ea6dc4f,
    128'head27321b58dbad2312bf5607f8d292f,
    128'hac7766f319fadc2128d12941575c006e,
    128'hd014f9a8c9ee2589e13f0cc8b6630ca6
  };
  localparam logic [7:0] RCON [1:10] = '{
    8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40, 8'h80, 8'h1b, 8'h36
  };

  function automatic logic [127:0] to_le(input logic [127:0] be);
    logic [127:0] r;
    for (int i = 0; i < 16; i++) r[8*i +: 8] = be[127-8*i -: 8];
    return r;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one operation and wait until its result is due
  task automatic run_op(input logic [127:0] a, input logic [7:0] rc);
    @(negedge clk);
    blk_in   = a;
    rc_in    = rc;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    logic [127:0] first;
    logic [127:0] prev;
    logic [31:0]  t;
    logic [31:0]  n0, n1, n2, n3;
    rst_n    = 1'b1;
    in_valid = 1'b0;
    blk_in   = '0;
    rc_in    = '0;
    #2 rst_n = 1'b0;
    @(negedge clk);
    chk("R8 reset", {127'd0, out_valid}, 128'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // key schedule through the vector table, R4
    prev = to_le(KEY_BE[0]);
    for (int r = 1; r <= 10; r++) begin
      run_op(prev, RCON[r]);
      chk("R7 valid", {127'd0, out_valid}, 128'd1);
      t  = blk_out[127:96];
      n0 = prev[31:0] ^ t;
      n1 = prev[63:32] ^ n0;
      n2 = prev[95:64] ^ n1;
      n3 = prev[127:96] ^ n2;
      chk("R4 round key", {n3, n2, n1, n0}, to_le(KEY_BE[r]));
      prev = to_le(KEY_BE[r]);
    end

    // directed word checks, R1 R2 R3
    run_op({32'h01000053, 32'h0, 32'h53ff0100, 32'h0}, 8'ha5);
    chk("R1 word0", {96'd0, blk_out[31:0]},  {96'd0, 32'hed167c63});
    chk("R2 word1", {96'd0, blk_out[63:32]}, {96'd0, 32'h63ed16d9});
    chk("R3 word2", {96'd0, blk_out[95:64]}, {96'd0, 32'h7c6363ed});
    chk("R4 word3", {96'd0, blk_out[127:96]},{96'd0, 32'hed7c63c6});
    first = blk_out;

    // R9: hold with in_valid low while inputs change
    blk_in = ~blk_in;
    rc_in  = 8'h3c;
    @(negedge clk);
    chk("R7 drop", {127'd0, out_valid}, 128'd0);
    chk("R9 hold", blk_out, first);

    // R5: words 0 and 2 ignored
    run_op({32'h01000053, 32'hdeadbeef, 32'h53ff0100, 32'h12345678}, 8'ha5);
    chk("R5 ignore W0 W2", blk_out, first);

    // R6: constant only in low byte of odd words
    run_op({32'h01000053, 32'h0, 32'h53ff0100, 32'h0}, 8'h00);
    first = blk_out;
    run_op({32'h01000053, 32'h0, 32'h53ff0100, 32'h0}, 8'hff);
    chk("R6 rcon span", blk_out ^ first, {32'h000000ff, 32'h0, 32'h000000ff, 32'h0});

    // all-zero input, R1 R3
    run_op(128'd0, 8'h00);
    chk("R1 R3 zero input", blk_out, {4{32'h63636363}});

    // R8: asynchronous clear mid-run
    @(negedge clk);
    in_valid = 1'b1;
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1 chk("R8 async clear", {127'd0, out_valid}, 128'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 stays clear", {127'd0, out_valid}, 128'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule